// File: doc/BRIEF.md
# Inter-Thread Signal and Wakeup Unit

This unit holds one signal record per software thread. A thread registers a mask of the signal numbers it waits for, together with its scheduling priority. Any agent may post a signal number to a target thread. The unit sets that signal's bit in the target's pending set. When the target waits for that signal, the unit also sends an interrupt to a compute unit. If the target already runs on a compute unit, that unit gets an arrival interrupt. If the target is not running, the unit picks a compute unit that runs lower-priority work and sends it a wakeup interrupt. Delivery therefore works like a hardware wakeup, and no software has to poll a flag.

A scheduler port keeps the residency table up to date: which thread each compute unit runs, or that the unit is idle. Compute units can also send direct interrupts to one another, independent of the signal path. Each compute unit has an interrupt pulse output, a sticky cause field that it clears with an acknowledge, and the number of the thread behind its most recent wakeup or arrival. A read port shows the pending set of any one record.

Top module: `sw_wakeup_unit`

## Requirements
- R1: A register operation writes the expected mask and the 4-bit priority of `reg_thread` and clears that record's pending set. The cleared set shows on `rd_pending` after the clock edge.
- R2: A post sets bit `post_sig` of the target record's pending set, whether or not the signal is expected. The set bit shows on `rd_pending` after the clock edge.
- R3: A post whose signal bit is 0 in the target's expected mask raises no interrupt.
- R4: An expected post to a thread that runs on a busy compute unit sets cause bit 1 (arrival) on the lowest-index unit that runs it. No other unit is interrupted.
- R5: An expected post to a thread that runs nowhere sets cause bit 0 (wakeup) on one busy unit. The unit chosen has the lowest running priority among those strictly below the target's priority, and ties go to the lowest index. Idle units are never chosen. If no unit qualifies, no interrupt is raised and the signal stays pending.
- R6: A direct interrupt to `ipi_dst` sets cause bit 2 of that unit.
- R7: `irq_pulse[i]` is high for exactly the one cycle after an event for unit i. Cause bits stay set until `irq_ack[i]`, and a new event in the same cycle as the acknowledge wins. `irq_thread` for unit i latches the target thread on each wakeup or arrival.
- R8: A register and a post to the same record in the same cycle resolve register-first. The post is judged against the new mask and the new priority, and its bit stays pending after the clear.
- R9: A scheduler write (busy flag and thread for a unit) takes effect on the next cycle. Decisions in that cycle use the residency and priority tables as they stood before the edge.
- R10: After reset, every unit is idle, every record is zero, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register operation strobe |
| reg_thread | input | 4 | Record being registered |
| reg_mask | input | 16 | New expected-signal mask |
| reg_prio | input | 4 | New thread priority (higher is more urgent) |
| post_valid | input | 1 | Signal post strobe |
| post_thread | input | 4 | Target thread of the post |
| post_sig | input | 4 | Signal number posted |
| sched_valid | input | 1 | Residency table write strobe |
| sched_cu | input | 2 | Compute unit being written |
| sched_run | input | 1 | 1: unit runs sched_thread, 0: unit idle |
| sched_thread | input | 4 | Thread placed on the unit |
| ipi_valid | input | 1 | Direct interrupt strobe |
| ipi_dst | input | 2 | Destination unit of the direct interrupt |
| irq_ack | input | 4 | Per-unit cause clear |
| rd_thread | input | 4 | Record shown on rd_pending |
| rd_pending | output | 16 | Pending set of rd_thread |
| irq_pulse | output | 4 | Per-unit one-cycle interrupt |
| irq_cause | output | 12 | Per-unit sticky cause, 3 bits per unit (0 wakeup, 1 arrival, 2 direct) |
| irq_thread | output | 16 | Per-unit thread of the last wakeup or arrival, 4 bits per unit |

## Verification
Each fault inside the unit shows at the ports one cycle after the operation that exposes it. A wrong residency or priority entry sends the wakeup to the wrong unit, or sends an arrival where a wakeup was due, in the cycle after the post. A corrupted expected mask either silences an interrupt or raises an unexpected one. A pending set that was recorded or cleared wrongly shows on `rd_pending` as soon as that record is selected. The random phase keeps changing residency, priorities and acknowledges, so that ties, idle units and targets with no eligible victim all occur many times.

// File: rtl/sw_wakeup_pkg.sv
package sw_wakeup_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CB_WAKE   = 0;
  localparam int CB_ARRIVE = 1;
  localparam int CB_DIRECT = 2;
endpackage

// File: rtl/sw_record_table.sv
module sw_record_table #(
  parameter int NTHR = 16,
  parameter int NSIG = 16,
  parameter int PRIW = 4,
  localparam int TW  = $clog2(NTHR),
  localparam int SW  = $clog2(NSIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_valid,
  input  logic [TW-1:0]   reg_thread,
  input  logic [NSIG-1:0] reg_mask,
  input  logic [PRIW-1:0] reg_prio,
  input  logic            post_valid,
  input  logic [TW-1:0]   post_thread,
  input  logic [SW-1:0]   post_sig,
  input  logic [TW-1:0]   rd_thread,
  output logic            post_expected,
  output logic [PRIW-1:0] post_prio,
  output logic [NSIG-1:0] rd_pending,
  output logic [PRIW-1:0] prio_q [NTHR]
);

  logic [NSIG-1:0] exp_q  [NTHR];
  logic [NSIG-1:0] pend_q [NTHR];
  logic [NSIG-1:0] exp_d  [NTHR];
  logic [NSIG-1:0] pend_d [NTHR];
  logic [PRIW-1:0] prio_d [NTHR];
  logic [NTHR-1:0] rec_en;
  logic            same_rec;
  logic [NSIG-1:0] eff_mask;

  // register-first: the post sees the mask and priority written this cycle
  assign same_rec      = reg_valid && (reg_thread == post_thread);
  assign eff_mask      = same_rec ? reg_mask : exp_q[post_thread];
  assign post_prio     = same_rec ? reg_prio : prio_q[post_thread];
  assign post_expected = eff_mask[post_sig];
  assign rd_pending    = pend_q[rd_thread];

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      exp_d[t]  = exp_q[t];
      prio_d[t] = prio_q[t];
      pend_d[t] = pend_q[t];
      rec_en[t] = 1'b0;
      if (reg_valid && (reg_thread == TW'(t))) begin
        exp_d[t]  = reg_mask;
        prio_d[t] = reg_prio;
        pend_d[t] = '0;
        rec_en[t] = 1'b1;
      end
      if (post_valid && (post_thread == TW'(t))) begin
        pend_d[t][post_sig] = 1'b1;
        rec_en[t]           = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        exp_q[t]  <= '0;
        prio_q[t] <= '0;
        pend_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        if (rec_en[t]) begin
          exp_q[t]  <= exp_d[t];
          prio_q[t] <= prio_d[t];
          pend_q[t] <= pend_d[t];
        end
      end
    end
  end

endmodule

// File: rtl/sw_victim_pick.sv
module sw_victim_pick #(
  parameter int NCU  = 4,
  parameter int PRIW = 4,
  localparam int CW  = $clog2(NCU)
) (
  input  logic [NCU-1:0]  cu_busy,
  input  logic [PRIW-1:0] cu_prio [NCU],
  input  logic [PRIW-1:0] tgt_prio,
  output logic            found,
  output logic [CW-1:0]   victim
);

  logic [PRIW-1:0] best;

  // strict compare keeps the lowest index on equal priorities
  always_comb begin
    found  = 1'b0;
    victim = '0;
    best   = '0;
    for (int i = 0; i < NCU; i++) begin
      if (cu_busy[i] && (cu_prio[i] < tgt_prio) && (!found || (cu_prio[i] < best))) begin
        found  = 1'b1;
        victim = CW'(i);
        best   = cu_prio[i];
      end
    end
  end

endmodule

// File: rtl/sw_irq_port.sv
module sw_irq_port
  import sw_wakeup_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_cause,
  input  logic [TW-1:0]      set_thread,
  input  logic               ack,
  output logic               irq_pulse,
  output logic [CAUSE_W-1:0] irq_cause,
  output logic [TW-1:0]      irq_thread
);

  logic [CAUSE_W-1:0] cause_d;
  logic               thr_en;

  assign cause_d = (ack ? '0 : irq_cause) | set_cause;
  assign thr_en  = set_cause[CB_WAKE] | set_cause[CB_ARRIVE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_pulse <= |set_cause;
      irq_cause <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_thread <= '0;
    end else if (thr_en) begin
      irq_thread <= set_thread;
    end
  end

endmodule

// File: rtl/sw_wakeup_unit.sv
module sw_wakeup_unit
  import sw_wakeup_pkg::*;
#(
  parameter int NTHR = 16,
  parameter int NSIG = 16,
  parameter int PRIW = 4,
  parameter int NCU  = 4,
  localparam int TW  = $clog2(NTHR),
  localparam int SW  = $clog2(NSIG),
  localparam int CW  = $clog2(NCU)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_valid,
  input  logic [TW-1:0]          reg_thread,
  input  logic [NSIG-1:0]        reg_mask,
  input  logic [PRIW-1:0]        reg_prio,
  input  logic                   post_valid,
  input  logic [TW-1:0]          post_thread,
  input  logic [SW-1:0]          post_sig,
  input  logic                   sched_valid,
  input  logic [CW-1:0]          sched_cu,
  input  logic                   sched_run,
  input  logic [TW-1:0]          sched_thread,
  input  logic                   ipi_valid,
  input  logic [CW-1:0]          ipi_dst,
  input  logic [NCU-1:0]         irq_ack,
  input  logic [TW-1:0]          rd_thread,
  output logic [NSIG-1:0]        rd_pending,
  output logic [NCU-1:0]         irq_pulse,
  output logic [NCU*CAUSE_W-1:0] irq_cause,
  output logic [NCU*TW-1:0]      irq_thread
);

  // reset: asserted at once, released through two flops
  logic rst_meta_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  // residency table
  logic [NCU-1:0] busy_q, busy_d;
  logic [TW-1:0]  thr_q [NCU];
  logic [TW-1:0]  thr_d [NCU];
  logic [NCU-1:0] cu_en;

  always_comb begin
    for (int i = 0; i < NCU; i++) begin
      busy_d[i] = busy_q[i];
      thr_d[i]  = thr_q[i];
      cu_en[i]  = sched_valid && (sched_cu == CW'(i));
      if (cu_en[i]) begin
        busy_d[i] = sched_run;
        thr_d[i]  = sched_thread;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      busy_q <= '0;
      for (int i = 0; i < NCU; i++) thr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCU; i++) begin
        if (cu_en[i]) begin
          busy_q[i] <= busy_d[i];
          thr_q[i]  <= thr_d[i];
        end
      end
    end
  end

  // records
  logic            post_expected;
  logic [PRIW-1:0] post_prio;
  logic [PRIW-1:0] prio_q [NTHR];

  sw_record_table #(.NTHR(NTHR), .NSIG(NSIG), .PRIW(PRIW)) u_tab (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .reg_valid    (reg_valid),
    .reg_thread   (reg_thread),
    .reg_mask     (reg_mask),
    .reg_prio     (reg_prio),
    .post_valid   (post_valid),
    .post_thread  (post_thread),
    .post_sig     (post_sig),
    .rd_thread    (rd_thread),
    .post_expected(post_expected),
    .post_prio    (post_prio),
    .rd_pending   (rd_pending),
    .prio_q       (prio_q)
  );

  // residency lookup and victim choice
  logic [PRIW-1:0] cu_prio [NCU];
  logic            res_hit;
  logic [CW-1:0]   res_cu;
  logic            vic_found;
  logic [CW-1:0]   vic_cu;

  always_comb begin
    res_hit = 1'b0;
    res_cu  = '0;
    for (int i = NCU - 1; i >= 0; i--) begin
      cu_prio[i] = prio_q[thr_q[i]];
      if (busy_q[i] && (thr_q[i] == post_thread)) begin
        res_hit = 1'b1;
        res_cu  = CW'(i);
      end
    end
  end

  sw_victim_pick #(.NCU(NCU), .PRIW(PRIW)) u_pick (
    .cu_busy (busy_q),
    .cu_prio (cu_prio),
    .tgt_prio(post_prio),
    .found   (vic_found),
    .victim  (vic_cu)
  );

  logic [NCU-1:0][CAUSE_W-1:0] set_c;
  always_comb begin
    set_c = '0;
    if (post_valid && post_expected) begin
      if (res_hit)        set_c[res_cu][CB_ARRIVE] = 1'b1;
      else if (vic_found) set_c[vic_cu][CB_WAKE]   = 1'b1;
    end
    if (ipi_valid) set_c[ipi_dst][CB_DIRECT] = 1'b1;
  end

  for (genvar i = 0; i < NCU; i++) begin : g_port
    sw_irq_port #(.TW(TW)) u_port (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .set_cause (set_c[i]),
      .set_thread(post_thread),
      .ack       (irq_ack[i]),
      .irq_pulse (irq_pulse[i]),
      .irq_cause (irq_cause[i*CAUSE_W +: CAUSE_W]),
      .irq_thread(irq_thread[i*TW +: TW])
    );
  end

endmodule

// File: rtl/sw_wakeup_chk.sv
module sw_wakeup_chk
  import sw_wakeup_pkg::*;
#(
  parameter int NCU = 4,
  parameter int CW  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   post_valid,
  input logic                   post_expected,
  input logic                   ipi_valid,
  input logic [CW-1:0]          ipi_dst,
  input logic [NCU-1:0]         irq_ack,
  input logic [NCU-1:0]         irq_pulse,
  input logic [NCU*CAUSE_W-1:0] irq_cause
);

  // R3: an unexpected post with no direct interrupt leaves every unit quiet
  assert_unexpected_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !post_expected && !ipi_valid) |=> (irq_pulse == '0));

  // R4 / R5: a post interrupts at most one unit
  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ipi_valid |=> $onehot0(irq_pulse));

  for (genvar i = 0; i < NCU; i++) begin : g_cu
    // R6: direct interrupt reaches its destination next cycle
    assert_direct_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_valid && ipi_dst == CW'(i)) |=> (irq_pulse[i] && irq_cause[i*CAUSE_W + CB_DIRECT]));

    // R7: acknowledge with no new event empties the cause field
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[i] && !post_valid && !ipi_valid) |=> (irq_cause[i*CAUSE_W +: CAUSE_W] == '0));

    // R7: a pulse always comes with a recorded cause
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |-> (irq_cause[i*CAUSE_W +: CAUSE_W] != '0));
  end

endmodule

bind sw_wakeup_unit sw_wakeup_chk #(.NCU(NCU), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_s_n),
  .post_valid   (post_valid),
  .post_expected(post_expected),
  .ipi_valid    (ipi_valid),
  .ipi_dst      (ipi_dst),
  .irq_ack      (irq_ack),
  .irq_pulse    (irq_pulse),
  .irq_cause    (irq_cause)
);

// File: tb/tb_sw_wakeup_unit.sv
module tb_sw_wakeup_unit;
  localparam int NTHR = 16, NSIG = 16, PRIW = 4, NCU = 4;
  localparam int TW = 4, SW = 4, CW = 2, CAW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic                reg_valid, post_valid, sched_valid, sched_run, ipi_valid;
  logic [TW-1:0]       reg_thread, post_thread, sched_thread, rd_thread;
  logic [NSIG-1:0]     reg_mask;
  logic [PRIW-1:0]     reg_prio;
  logic [SW-1:0]       post_sig;
  logic [CW-1:0]       sched_cu, ipi_dst;
  logic [NCU-1:0]      irq_ack;
  logic [NSIG-1:0]     rd_pending;
  logic [NCU-1:0]      irq_pulse;
  logic [NCU*CAW-1:0]  irq_cause;
  logic [NCU*TW-1:0]   irq_thread;

  sw_wakeup_unit dut (.*);

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [NSIG-1:0] m_exp [NTHR];
  logic [NSIG-1:0] m_pend[NTHR];
  logic [PRIW-1:0] m_pr  [NTHR];
  logic            m_busy[NCU];
  logic [TW-1:0]   m_thr [NCU];
  logic [CAW-1:0]  m_cause[NCU];
  logic [TW-1:0]   m_lth [NCU];
  logic [NCU-1:0]  m_pulse;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_valid = 0; post_valid = 0; sched_valid = 0; ipi_valid = 0; irq_ack = '0;
    reg_thread = '0; reg_mask = '0; reg_prio = '0; post_thread = '0; post_sig = '0;
    sched_cu = '0; sched_run = 0; sched_thread = '0; ipi_dst = '0;
  endtask

  // evaluate the model on the driven inputs, clock once, compare
  task automatic step(string tag);
    logic [NSIG-1:0] em;
    logic [PRIW-1:0] ep, bp;
    logic [CAW-1:0]  nc [NCU];
    logic [NCU*CAW-1:0] ec;
    logic [NCU*TW-1:0]  et;
    int hit, best;
    for (int i = 0; i < NCU; i++) nc[i] = '0;
    em = (reg_valid && reg_thread == post_thread) ? reg_mask : m_exp[post_thread];
    ep = (reg_valid && reg_thread == post_thread) ? reg_prio : m_pr[post_thread];
    bp = '0;
    if (post_valid && em[post_sig]) begin
      hit = -1;
      for (int i = NCU - 1; i >= 0; i--) if (m_busy[i] && m_thr[i] == post_thread) hit = i;
      if (hit >= 0) begin
        nc[hit][1] = 1'b1; m_lth[hit] = post_thread;
      end else begin
        best = -1;
        for (int i = 0; i < NCU; i++)
          if (m_busy[i] && m_pr[m_thr[i]] < ep && (best < 0 || m_pr[m_thr[i]] < bp)) begin
            best = i; bp = m_pr[m_thr[i]];
          end
        if (best >= 0) begin nc[best][0] = 1'b1; m_lth[best] = post_thread; end
      end
    end
    if (ipi_valid) nc[ipi_dst][2] = 1'b1;
    for (int i = 0; i < NCU; i++) begin
      m_cause[i] = (irq_ack[i] ? 3'b000 : m_cause[i]) | nc[i];
      m_pulse[i] = |nc[i];
    end
    if (reg_valid) begin
      m_exp[reg_thread] = reg_mask; m_pr[reg_thread] = reg_prio; m_pend[reg_thread] = '0;
    end
    if (post_valid) m_pend[post_thread][post_sig] = 1'b1;
    if (sched_valid) begin m_busy[sched_cu] = sched_run; m_thr[sched_cu] = sched_thread; end
    for (int i = 0; i < NCU; i++) begin
      ec[i*CAW +: CAW] = m_cause[i];
      et[i*TW +: TW]   = m_lth[i];
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "irq_pulse", 64'(irq_pulse), 64'(m_pulse));
    check(tag, "irq_cause", 64'(irq_cause), 64'(ec));
    check(tag, "irq_thread", 64'(irq_thread), 64'(et));
    check(tag, "rd_pending", 64'(rd_pending), 64'(m_pend[rd_thread]));
    idle_inputs();
  endtask

  task automatic do_reg(logic [TW-1:0] t, logic [NSIG-1:0] m, logic [PRIW-1:0] p, string tag);
    reg_valid = 1; reg_thread = t; reg_mask = m; reg_prio = p; rd_thread = t;
    step(tag);
  endtask

  task automatic do_sched(logic [CW-1:0] c, logic run, logic [TW-1:0] t, string tag);
    sched_valid = 1; sched_cu = c; sched_run = run; sched_thread = t;
    step(tag);
  endtask

  task automatic do_post(logic [TW-1:0] t, logic [SW-1:0] s, string tag);
    post_valid = 1; post_thread = t; post_sig = s; rd_thread = t;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1989));
    for (int t = 0; t < NTHR; t++) begin m_exp[t] = '0; m_pend[t] = '0; m_pr[t] = '0; end
    for (int i = 0; i < NCU; i++) begin
      m_busy[i] = 0; m_thr[i] = '0; m_cause[i] = '0; m_lth[i] = '0;
    end
    m_pulse = '0;
    idle_inputs();
    rd_thread = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "irq_pulse", 64'(irq_pulse), 64'd0);
    check("R10", "irq_cause", 64'(irq_cause), 64'd0);
    check("R10", "irq_thread", 64'(irq_thread), 64'd0);
    check("R10", "rd_pending", 64'(rd_pending), 64'd0);

    // R1 R2 R3: thread 3 waits on signal 5 only, prio 5
    do_reg(4'd3, 16'h0020, 4'd5, "R1");
    do_post(4'd3, 4'd2, "R3");
    check("R2", "pending bit 2", 64'(rd_pending), 64'h0004);
    do_reg(4'd3, 16'h0020, 4'd5, "R1");
    check("R1", "pending cleared", 64'(rd_pending), 64'h0000);

    // R9 R5: prios 2,1,1 running on units 0..2, unit 3 idle
    do_reg(4'd1, 16'h0000, 4'd2, "R1");
    do_reg(4'd2, 16'h0000, 4'd1, "R1");
    do_reg(4'd4, 16'h0000, 4'd1, "R1");
    do_sched(2'd0, 1'b1, 4'd1, "R9");
    do_sched(2'd1, 1'b1, 4'd2, "R9");
    do_sched(2'd2, 1'b1, 4'd4, "R9");
    do_post(4'd3, 4'd5, "R5");
    check("R5", "tie to unit 1", 64'(irq_pulse), 64'b0010);
    irq_ack = 4'b1111; step("R7");
    check("R7", "cause cleared", 64'(irq_cause), 64'd0);

    // R5: no eligible victim
    do_reg(4'd3, 16'h0020, 4'd0, "R1");
    do_post(4'd3, 4'd5, "R5");
    check("R5", "none eligible", 64'(irq_pulse), 64'd0);

    // R4: resident target; R9 same-cycle placement still uses old table
    sched_valid = 1; sched_cu = 2'd3; sched_run = 1; sched_thread = 4'd3;
    post_valid = 1; post_thread = 4'd3; post_sig = 4'd5; rd_thread = 4'd3;
    step("R9");
    do_post(4'd3, 4'd5, "R4");
    check("R4", "arrival on unit 3", 64'(irq_pulse), 64'b1000);

    // R8: register and post in one cycle for thread 6
    reg_valid = 1; reg_thread = 4'd6; reg_mask = 16'h0200; reg_prio = 4'd9;
    post_valid = 1; post_thread = 4'd6; post_sig = 4'd9; rd_thread = 4'd6;
    step("R8");
    check("R8", "pending kept", 64'(rd_pending), 64'h0200);

    // R6 R7: direct interrupt with simultaneous ack on same unit
    irq_ack = 4'b0100; ipi_valid = 1; ipi_dst = 2'd2; step("R6");
    irq_ack = 4'b0100; ipi_valid = 1; ipi_dst = 2'd2; step("R7");
    step("R7");
    check("R7", "pulse one cycle", 64'(irq_pulse), 64'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) begin
        reg_valid = 1; reg_thread = TW'($urandom); reg_mask = NSIG'($urandom); reg_prio = PRIW'($urandom);
      end
      if ($urandom_range(1) == 0) begin
        post_valid = 1; post_thread = TW'($urandom); post_sig = SW'($urandom);
      end
      if ($urandom_range(5) == 0) begin
        sched_valid = 1; sched_cu = CW'($urandom); sched_run = ($urandom_range(3) != 0);
        sched_thread = TW'($urandom);
      end
      if ($urandom_range(7) == 0) begin ipi_valid = 1; ipi_dst = CW'($urandom); end
      for (int i = 0; i < NCU; i++) irq_ack[i] = ($urandom_range(2) == 0);
      rd_thread = TW'($urandom);
      step("R5");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule